// File: doc/BRIEF.md
# Chainable Serial Setup Loader

This block fills the per-queue setup storage of a multi-queue buffer from a one-bit serial port. A serial clock, a data input and an active-low enable input feed a bit counter. Each enabled rising edge stores one bit, either into a global header or into one of the per-queue records. The header names how many queues are in use, so the block knows how many bits belong to it. It absorbs exactly that many bits, then raises its done flag and asserts its active-low enable output.

After it is done, the block is transparent. Its enable output and data output follow its enable and data inputs, so any further bits pass straight through to the next device. Several instances can share one serial clock, with each data/enable output pair wired to the next instance's inputs. One stream then programs the whole chain, first device first. The last device's enable output going low means the whole chain is configured. The buffer datapath reads the stored setup through a queue-select lookup port.

Top module: `sc_serial_cfg_loader`

## Requirements
- R1: A device takes exactly 19 + 72·Q enabled bits, where Q is one plus the value of header bits [2:0]. Q ranges from 1 to 8.
- R2: A bit is stored only on a rising edge of `clk` while `sen_n` is low. Edges with `sen_n` high do not advance loading.
- R3: `cfg_valid` rises and `seno_n` goes low right after the last bit of the device is taken, and not after the bit before it.
- R4: Once loading is complete, `seno_n` equals `sen_n`, so it goes high again when `sen_n` goes high.
- R5: Once loading is complete, `sdo` equals `sdi`.
- R6: In a chain whose data/enable outputs feed the next device's inputs, the second device is loaded from the bits that follow the first device's share. Its `seno_n` goes low only when both are loaded.
- R7: While `rst_n` is low, the bit counter, the done flag and all setup storage are cleared, and clock edges are ignored. Loading starts afresh once `rst_n` is released.
- R8: Enabled clocks after completion leave the header and every record unchanged.
- R9: Until loading completes, `sdo` and `seno_n` are held high.
- R10: Header stream bit i lands in `cfg_hdr[i]`. Record k takes the next 72 bits LSB first. Its bits [23:0] appear on `cfg_depth`, [47:24] on `cfg_ae` and [71:48] on `cfg_af` when `cfg_sel` = k.
- R11: `cfg_qcount` equals header bits [2:0] plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| sdi | input | 1 | Serial data in |
| sen_n | input | 1 | Serial enable in, active low |
| sdo | output | 1 | Serial data out (pass-through once loaded) |
| seno_n | output | 1 | Enable out, active low; low means this device and all before it are loaded |
| cfg_sel | input | 3 | Queue whose record is shown on the lookup outputs |
| cfg_valid | output | 1 | Loading complete |
| cfg_qcount | output | 4 | Configured queue count |
| cfg_hdr | output | 19 | Stored header |
| cfg_depth | output | 24 | Depth field of the selected queue |
| cfg_ae | output | 24 | Almost-empty offset of the selected queue |
| cfg_af | output | 24 | Almost-full offset of the selected queue |

## Verification
The bench builds two instances with the default parameters: a 19-bit header, 72-bit records of three 24-bit fields, and up to 8 queues. They are wired as a two-device chain. This brings the smallest (Q=1) and largest (Q=8) stream lengths within reach, as well as mid sizes (Q=2, Q=3). It also exercises the hand-over point where the first device turns transparent and the second starts counting. Idle clocks with the enable high are scattered through the stream, surplus bits follow completion, and a reset between two full loads proves that stored state is rebuilt from nothing.

// File: rtl/sc_cfg_pkg.sv
package sc_cfg_pkg;
  localparam int HDR_W = 19;  // header bits
  localparam int FLD_W = 24;  // one setup field
  localparam int REC_W = 72;  // three fields per queue
  localparam int MAX_Q = 8;

  // Number of enabled clocks a single device consumes for qm1 = Q-1.
  function automatic int stream_bits(int hdr_w, int rec_w, int qm1);
    return hdr_w + rec_w * (qm1 + 1);
  endfunction
endpackage

// File: rtl/sc_seq_ctrl.sv
module sc_seq_ctrl #(
  parameter int HDR_W = sc_cfg_pkg::HDR_W,
  parameter int REC_W = sc_cfg_pkg::REC_W,
  parameter int MAX_Q = sc_cfg_pkg::MAX_Q,
  localparam int SEG_MAX = (REC_W > HDR_W) ? REC_W : HDR_W,
  localparam int SEG_W = $clog2(SEG_MAX),
  localparam int QI_W = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [QI_W-1:0]  qm1,
  output logic             in_hdr,
  output logic [SEG_W-1:0] seg_pos,
  output logic [QI_W-1:0]  rec_idx,
  output logic             done
);
  logic seg_last;

  always_comb begin
    if (in_hdr) seg_last = (seg_pos == SEG_W'(HDR_W - 1));
    else        seg_last = (seg_pos == SEG_W'(REC_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hdr  <= 1'b1;
      seg_pos <= '0;
      rec_idx <= '0;
      done    <= 1'b0;
    end else if (shift) begin
      if (seg_last) begin
        seg_pos <= '0;
        if (in_hdr)              in_hdr  <= 1'b0;
        else if (rec_idx == qm1) done    <= 1'b1;
        else                     rec_idx <= rec_idx + 1'b1;
      end else begin
        seg_pos <= seg_pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_setup_bank.sv
module sc_setup_bank #(
  parameter int HDR_W = sc_cfg_pkg::HDR_W,
  parameter int REC_W = sc_cfg_pkg::REC_W,
  parameter int MAX_Q = sc_cfg_pkg::MAX_Q,
  localparam int SEG_MAX = (REC_W > HDR_W) ? REC_W : HDR_W,
  localparam int SEG_W = $clog2(SEG_MAX),
  localparam int QI_W = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi,
  input  logic             hdr_we,
  input  logic             rec_we,
  input  logic [SEG_W-1:0] seg_pos,
  input  logic [QI_W-1:0]  rec_idx,
  input  logic [QI_W-1:0]  rd_sel,
  output logic [HDR_W-1:0] hdr,
  output logic [REC_W-1:0] rd_rec
);
  logic [REC_W-1:0] rec_arr [MAX_Q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr <= '0;
    end else if (hdr_we) begin
      for (int b = 0; b < HDR_W; b++)
        if (seg_pos == SEG_W'(b)) hdr[b] <= sdi;
    end
  end

  for (genvar g = 0; g < MAX_Q; g++) begin : g_queue
    logic [REC_W-1:0] rec_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec_r <= '0;
      end else if (rec_we && (rec_idx == QI_W'(g))) begin
        for (int b = 0; b < REC_W; b++)
          if (seg_pos == SEG_W'(b)) rec_r[b] <= sdi;
      end
    end
    assign rec_arr[g] = rec_r;
  end

  assign rd_rec = rec_arr[rd_sel];
endmodule

// File: rtl/sc_passthru.sv
module sc_passthru (
  input  logic done,
  input  logic sen_n,
  input  logic sdi,
  output logic seno_n,
  output logic sdo
);
  assign seno_n = done ? sen_n : 1'b1;
  assign sdo    = done ? sdi   : 1'b1;
endmodule

// File: rtl/sc_serial_cfg_loader.sv
module sc_serial_cfg_loader #(
  parameter int HDR_W = sc_cfg_pkg::HDR_W,
  parameter int FLD_W = sc_cfg_pkg::FLD_W,
  parameter int MAX_Q = sc_cfg_pkg::MAX_Q,
  localparam int REC_W = 3 * FLD_W,
  localparam int SEG_MAX = (REC_W > HDR_W) ? REC_W : HDR_W,
  localparam int SEG_W = $clog2(SEG_MAX),
  localparam int QI_W = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int QC_W = $clog2(MAX_Q + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi,
  input  logic             sen_n,
  output logic             sdo,
  output logic             seno_n,
  input  logic [QI_W-1:0]  cfg_sel,
  output logic             cfg_valid,
  output logic [QC_W-1:0]  cfg_qcount,
  output logic [HDR_W-1:0] cfg_hdr,
  output logic [FLD_W-1:0] cfg_depth,
  output logic [FLD_W-1:0] cfg_ae,
  output logic [FLD_W-1:0] cfg_af
);
  // Named internal events, visible to the bound checker.
  logic             shift_w;
  logic             done_w;
  logic             in_hdr_w;
  logic [SEG_W-1:0] seg_pos_w;
  logic [QI_W-1:0]  rec_idx_w;
  logic [QI_W-1:0]  qm1_w;
  logic [HDR_W-1:0] hdr_w;
  logic [REC_W-1:0] rd_rec_w;

  assign shift_w = !sen_n && !done_w;
  assign qm1_w   = hdr_w[QI_W-1:0];

  sc_seq_ctrl #(.HDR_W(HDR_W), .REC_W(REC_W), .MAX_Q(MAX_Q)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .shift(shift_w), .qm1(qm1_w),
    .in_hdr(in_hdr_w), .seg_pos(seg_pos_w), .rec_idx(rec_idx_w), .done(done_w)
  );

  sc_setup_bank #(.HDR_W(HDR_W), .REC_W(REC_W), .MAX_Q(MAX_Q)) u_bank (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .hdr_we(shift_w && in_hdr_w), .rec_we(shift_w && !in_hdr_w),
    .seg_pos(seg_pos_w), .rec_idx(rec_idx_w), .rd_sel(cfg_sel),
    .hdr(hdr_w), .rd_rec(rd_rec_w)
  );

  sc_passthru u_pass (
    .done(done_w), .sen_n(sen_n), .sdi(sdi), .seno_n(seno_n), .sdo(sdo)
  );

  assign cfg_valid  = done_w;
  assign cfg_hdr    = hdr_w;
  assign cfg_qcount = QC_W'(qm1_w) + 1'b1;
  assign cfg_depth  = rd_rec_w[FLD_W-1:0];
  assign cfg_ae     = rd_rec_w[2*FLD_W-1:FLD_W];
  assign cfg_af     = rd_rec_w[3*FLD_W-1:2*FLD_W];
endmodule

// File: rtl/sc_cfg_checker.sv
module sc_cfg_checker #(
  parameter int HDR_W = sc_cfg_pkg::HDR_W,
  parameter int REC_W = sc_cfg_pkg::REC_W,
  parameter int MAX_Q = sc_cfg_pkg::MAX_Q,
  localparam int SEG_MAX = (REC_W > HDR_W) ? REC_W : HDR_W,
  localparam int SEG_W = $clog2(SEG_MAX),
  localparam int QI_W = (MAX_Q > 1) ? $clog2(MAX_Q) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sen_n,
  input logic             sdi,
  input logic             sdo,
  input logic             seno_n,
  input logic             done,
  input logic             shift,
  input logic [SEG_W-1:0] seg_pos,
  input logic [QI_W-1:0]  rec_idx,
  input logic [QI_W-1:0]  qm1,
  input logic [HDR_W-1:0] hdr
);
  logic [15:0] n_taken;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     n_taken <= '0;
    else if (shift) n_taken <= n_taken + 1'b1;
  end

  // R1: completion lands exactly on the computed stream length
  a_r1_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (n_taken == 16'(sc_cfg_pkg::stream_bits(HDR_W, REC_W, int'(qm1)))));

  // R2: a disabled edge does not move the load position
  a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_n && !done) |=> ($stable(seg_pos) && $stable(rec_idx) && $stable(hdr)));

  // R3: completion is sticky until reset
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R4: enable out mirrors enable in after completion
  a_r4_enable_follow: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seno_n == sen_n));

  // R5: data out mirrors data in after completion
  a_r5_data_follow: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sdo == sdi));

  // R8: header frozen once loaded
  a_r8_hdr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(hdr));

  // R9: outputs parked high before completion
  a_r9_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (seno_n && sdo));
endmodule

bind sc_serial_cfg_loader sc_cfg_checker #(
  .HDR_W(HDR_W), .REC_W(REC_W), .MAX_Q(MAX_Q)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sdi(sdi), .sdo(sdo),
  .seno_n(seno_n), .done(done_w), .shift(shift_w), .seg_pos(seg_pos_w),
  .rec_idx(rec_idx_w), .qm1(qm1_w), .hdr(hdr_w)
);

// File: tb/tb_sc_serial_cfg_loader.sv
module tb_sc_serial_cfg_loader;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n, sdi, sen_n;
  logic        sdo0, seno0, sdo1, seno1;
  logic [2:0]  sel0, sel1;
  logic        val0, val1;
  logic [3:0]  qc0, qc1;
  logic [18:0] hdr0, hdr1;
  logic [23:0] dp0, ae0, af0, dp1, ae1, af1;

  sc_serial_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sen_n(sen_n), .sdo(sdo0), .seno_n(seno0),
    .cfg_sel(sel0), .cfg_valid(val0), .cfg_qcount(qc0), .cfg_hdr(hdr0),
    .cfg_depth(dp0), .cfg_ae(ae0), .cfg_af(af0));

  sc_serial_cfg_loader dut2 (
    .clk(clk), .rst_n(rst_n), .sdi(sdo0), .sen_n(seno0), .sdo(sdo1), .seno_n(seno1),
    .cfg_sel(sel1), .cfg_valid(val1), .cfg_qcount(qc1), .cfg_hdr(hdr1),
    .cfg_depth(dp1), .cfg_ae(ae1), .cfg_af(af1));

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected content, computed from R10/R11 layout.
  function automatic logic [71:0] mk_rec(int seed, int k);
    logic [23:0] d, e, f;
    d = 24'(seed * 4096 + k * 531 + 7);
    e = 24'(seed * 17 + k * 3 + 1);
    f = ~24'(seed * 255 + k);
    return {f, e, d};
  endfunction
  function automatic logic [18:0] mk_hdr(int seed, int q);
    return {16'(seed * 40503 + 1234), 3'(q - 1)};
  endfunction

  // Scoreboard: kind 0 header, 1 queue count, 2 record
  typedef struct { string req; int dev; int kind; int sel; logic [71:0] val; } item_t;
  item_t sb[$];

  task automatic push_dev(string req, int dev, int seed, int q);
    sb.push_back('{req, dev, 0, 0, 72'(mk_hdr(seed, q))});
    sb.push_back('{"R11", dev, 1, 0, 72'(q)});
    for (int k = 0; k < q; k++) sb.push_back('{req, dev, 2, k, mk_rec(seed, k)});
  endtask

  // Monitor: pops expected items and compares against the lookup outputs.
  task automatic drain();
    item_t it;
    logic [71:0] act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      if (it.dev == 0) sel0 = 3'(it.sel); else sel1 = 3'(it.sel);
      #2;
      case (it.kind)
        0: act = 72'(it.dev == 0 ? hdr0 : hdr1);
        1: act = 72'(it.dev == 0 ? qc0 : qc1);
        default: act = (it.dev == 0) ? {af0, ae0, dp0} : {af1, ae1, dp1};
      endcase
      chk(it.req, act, it.val);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); sdi = b; sen_n = 1'b0;
    @(posedge clk);
  endtask
  task automatic idle();
    @(negedge clk); sen_n = 1'b1; sdi = 1'($urandom);
    @(posedge clk);
  endtask

  // Driver: streams one device's share, with disabled gaps (R2).
  task automatic load_dev(int dev, int seed, int q);
    logic [18:0] h;
    logic [71:0] r;
    int total, n;
    h = mk_hdr(seed, q);
    total = 19 + 72 * q;
    n = 0;
    for (int i = 0; i < total; i++) begin
      logic b;
      if (i < 19) b = h[i];
      else begin r = mk_rec(seed, (i - 19) / 72); b = r[(i - 19) % 72]; end
      if (i % 37 == 36) idle();
      if (i == total - 1) begin
        #5;
        chk("R3 not early", 72'(dev == 0 ? val0 : val1), 72'(0));
        chk("R9 enable parked", 72'(dev == 0 ? seno0 : seno1), 72'(1));
        if (dev == 0) chk("R9 data parked", 72'(sdo0), 72'(1));
      end
      send_bit(b);
      n++;
    end
    #5;
    chk("R1 R3 done at length", 72'(dev == 0 ? val0 : val1), 72'(1));
    chk(dev == 0 ? "R3 enable low" : "R6 chain end low", 72'(dev == 0 ? seno0 : seno1), 72'(0));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sen_n = 1'b1; sdi = 1'b1; sel0 = '0; sel1 = '0;
    // R7: enabled clocks during reset are ignored
    repeat (4) begin @(negedge clk); sen_n = 1'b0; sdi = 1'($urandom); end
    #5;
    chk("R7 reset valid", 72'(val0), 72'(0));
    chk("R7 reset hdr", 72'(hdr0), 72'(0));
    chk("R9 reset enable out", 72'(seno0), 72'(1));
    chk("R9 reset data out", 72'(sdo0), 72'(1));
    @(negedge clk); sen_n = 1'b1; rst_n = 1'b1;

    // Round 1: first device Q=3, second Q=1
    load_dev(0, 1, 3);
    @(negedge clk); sen_n = 1'b1; #1;
    chk("R4 enable follows high", 72'(seno0), 72'(1));
    sdi = 1'b0; #1;
    chk("R5 data follows 0", 72'(sdo0), 72'(0));
    sdi = 1'b1; #1;
    chk("R5 data follows 1", 72'(sdo0), 72'(1));
    chk("R6 second not done", 72'(val1), 72'(0));
    push_dev("R10", 0, 1, 3);
    drain();
    load_dev(1, 2, 1);
    @(negedge clk); sen_n = 1'b1;
    push_dev("R6 R10", 1, 2, 1);
    drain();

    // R8: surplus enabled clocks
    for (int i = 0; i < 100; i++) send_bit(1'($urandom));
    @(negedge clk); sen_n = 1'b1;
    push_dev("R8", 0, 1, 3);
    push_dev("R8", 1, 2, 1);
    drain();

    // R7: reset clears, then a fresh load with Q=8 and Q=2
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 clear valid", 72'(val0), 72'(0));
    chk("R7 clear chain", 72'(seno1), 72'(1));
    sel0 = 3'd2; #1;
    chk("R7 clear record", {af0, ae0, dp0}, 72'(0));
    @(negedge clk); rst_n = 1'b1;
    load_dev(0, 3, 8);
    load_dev(1, 4, 2);
    @(negedge clk); sen_n = 1'b1;
    push_dev("R1 R10 max", 0, 3, 8);
    push_dev("R6 R10", 1, 4, 2);
    drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule